// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches virtual-page to physical-frame translations in a fully associative array. Every slot carries a page tag, an address space number and a global bit that lets the slot match in any space. A lookup port compares a virtual page number and the current space number against all slots at once. Within the same cycle it returns a hit flag, the index of the matching slot and the stored payload. The payload is a frame number, per-mode read and write enable masks, and fault-on-read and fault-on-write bits.

Beside the lookup port, a maintenance port accepts at most one command per cycle:

- an insert, which always writes the slot named by a rotating victim pointer;
- a flush of everything;
- a flush of one page under the lookup matching rule;
- a flush of every non-global slot.

Lookups read the current contents. Maintenance writes land at the next clock edge. Walking page tables, checking permissions and reporting faults are left to the surrounding logic.

The depth is a parameter. A depth of 48 suits instruction-side use and 64 suits data-side use, and 64 is the default.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only when a slot is valid, its tag equals `lk_vpn`, and either its global bit is set or its stored space number equals `lk_asn`.
- R2: When several slots hit, `lk_idx` reports the lowest-numbered one, and the payload outputs come from that slot.
- R3: On a hit, `lk_pfn`, `lk_rd_en`, `lk_wr_en`, `lk_frd` and `lk_fwr` equal the values stored by the insert that filled the slot. On a miss, `lk_hit`, `lk_idx` and all payload outputs are zero.
- R4: Opcode 1 (insert) writes the page, space number, global bit and payload into the slot named by the victim pointer and marks it valid, overwriting any valid content there. The pointer then advances by one, wrapping from the last slot to slot 0.
- R5: Opcode 2 (flush all) invalidates every slot and returns the victim pointer to slot 0.
- R6: Opcode 3 (flush page) invalidates exactly the slots that a lookup with `mt_vpn`/`mt_asn` would hit under R1, including global slots with that tag. All other slots stay valid.
- R7: Opcode 4 (flush non-global) invalidates every slot whose global bit is clear and keeps global slots.
- R8: After reset, every slot is invalid and the victim pointer is at slot 0.
- R9: A lookup sees the contents before any maintenance command issued in the same cycle. The command's effect is visible from the next cycle.
- R10: Opcode 0 and opcodes 5 to 7 change neither the contents nor the victim pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asn | input | ASN_W | Current address space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the hitting slot |
| lk_pfn | output | PFN_W | Physical frame number of the hitting slot |
| lk_rd_en | output | MODES | Per-mode read enable mask |
| lk_wr_en | output | MODES | Per-mode write enable mask |
| lk_frd | output | 1 | Fault-on-read bit |
| lk_fwr | output | 1 | Fault-on-write bit |
| mt_op | input | 3 | Maintenance opcode (0 idle, 1 insert, 2 flush all, 3 flush page, 4 flush non-global) |
| mt_vpn | input | VPN_W | Page for insert or flush page |
| mt_asn | input | ASN_W | Space number for insert or flush page |
| mt_global | input | 1 | Global bit for insert |
| mt_pfn | input | PFN_W | Frame number for insert |
| mt_rd_en | input | MODES | Read enable mask for insert |
| mt_wr_en | input | MODES | Write enable mask for insert |
| mt_frd | input | 1 | Fault-on-read bit for insert |
| mt_fwr | input | 1 | Fault-on-write bit for insert |

## Verification
The hardest situation to reach is several slots holding the same page. For example, a non-global slot in one space, another in a second space, and a global copy. Lookups must then pick the lowest index, and flushing the page must take the global copy as well as the matching space.

The ports cannot place entries directly, so the stimulus builds this state with directed inserts at known pointer positions. It then wraps the pointer so that an overwrite removes one of the duplicates. A long random phase follows that draws pages and spaces from small pools, so that collisions and duplicate tags recur constantly.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE        = 3'd0,
    OP_INSERT      = 3'd1,
    OP_FLUSH_ALL   = 3'd2,
    OP_FLUSH_PAGE  = 3'd3,
    OP_FLUSH_LOCAL = 3'd4
  } tlb_op_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 64,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8
) (
  input  logic [N-1:0]     valid,
  input  logic [VPN_W-1:0] tag   [N],
  input  logic [ASN_W-1:0] asn   [N],
  input  logic [N-1:0]     glob,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [ASN_W-1:0] q_asn,
  output logic [N-1:0]     hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic tag_eq;
    logic space_ok;
    assign tag_eq     = (tag[i] == q_vpn);
    assign space_ok   = glob[i] | (asn[i] == q_asn);
    assign hit_vec[i] = valid[i] & tag_eq & space_ok;
  end
endmodule

// File: rtl/tlb_lowest.sv
module tlb_lowest #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = clr | adv;
    ptr_d  = ptr_q;
    if (clr)
      ptr_d = '0;
    else if (adv)
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (ptr_en)
      ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr_q == LAST) |=> (ptr_q == '0)); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R4
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N     = 64,
  parameter int IDX_W = 6,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8,
  parameter int PFN_W = 28,
  parameter int MODES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [ASN_W-1:0] wr_asn,
  input  logic             wr_glob,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic [MODES-1:0] wr_rd,
  input  logic [MODES-1:0] wr_wr,
  input  logic             wr_frd,
  input  logic             wr_fwr,
  input  logic             clr_all,
  input  logic [N-1:0]     inv_vec,
  output logic [N-1:0]     valid,
  output logic [VPN_W-1:0] tag   [N],
  output logic [ASN_W-1:0] asn   [N],
  output logic [N-1:0]     glob,
  output logic [PFN_W-1:0] pfn   [N],
  output logic [MODES-1:0] rd_en [N],
  output logic [MODES-1:0] wr_en_m [N],
  output logic [N-1:0]     frd,
  output logic [N-1:0]     fwr
);
  logic [N-1:0] valid_q;
  logic [N-1:0] valid_d;
  logic [N-1:0] slot_we;
  logic         valid_en;

  for (genvar i = 0; i < N; i++) begin : g_we
    assign slot_we[i] = wr_en & (wr_idx == IDX_W'(i));
  end

  always_comb begin
    valid_en = clr_all | wr_en | (|inv_vec);
    if (clr_all)
      valid_d = '0;
    else
      valid_d = (valid_q & ~inv_vec) | slot_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= '0;
    else if (valid_en)
      valid_q <= valid_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [VPN_W-1:0] tag_q;
    logic [ASN_W-1:0] asn_q;
    logic             glob_q;
    logic [PFN_W-1:0] pfn_q;
    logic [MODES-1:0] rd_q;
    logic [MODES-1:0] wr_q;
    logic             frd_q;
    logic             fwr_q;

    always_ff @(posedge clk) begin
      if (slot_we[i]) begin
        tag_q  <= wr_vpn;
        asn_q  <= wr_asn;
        glob_q <= wr_glob;
        pfn_q  <= wr_pfn;
        rd_q   <= wr_rd;
        wr_q   <= wr_wr;
        frd_q  <= wr_frd;
        fwr_q  <= wr_fwr;
      end
    end

    assign tag[i]     = tag_q;
    assign asn[i]     = asn_q;
    assign glob[i]    = glob_q;
    assign pfn[i]     = pfn_q;
    assign rd_en[i]   = rd_q;
    assign wr_en_m[i] = wr_q;
    assign frd[i]     = frd_q;
    assign fwr[i]     = fwr_q;
  end

  assign valid = valid_q;

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_q == '0)); // R5

  AST_WRITE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all) |=> valid_q[$past(wr_idx)]); // R4
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 30,
  parameter int ASN_W   = 8,
  parameter int PFN_W   = 28,
  parameter int MODES   = 4,
  localparam int IDX_W  = tlb_pkg::idx_width(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [MODES-1:0] lk_rd_en,
  output logic [MODES-1:0] lk_wr_en,
  output logic             lk_frd,
  output logic             lk_fwr,
  input  logic [2:0]       mt_op,
  input  logic [VPN_W-1:0] mt_vpn,
  input  logic [ASN_W-1:0] mt_asn,
  input  logic             mt_global,
  input  logic [PFN_W-1:0] mt_pfn,
  input  logic [MODES-1:0] mt_rd_en,
  input  logic [MODES-1:0] mt_wr_en,
  input  logic             mt_frd,
  input  logic             mt_fwr
);
  logic [ENTRIES-1:0] s_valid;
  logic [VPN_W-1:0]   s_tag  [ENTRIES];
  logic [ASN_W-1:0]   s_asn  [ENTRIES];
  logic [ENTRIES-1:0] s_glob;
  logic [PFN_W-1:0]   s_pfn  [ENTRIES];
  logic [MODES-1:0]   s_rd   [ENTRIES];
  logic [MODES-1:0]   s_wr   [ENTRIES];
  logic [ENTRIES-1:0] s_frd;
  logic [ENTRIES-1:0] s_fwr;

  logic [ENTRIES-1:0] lk_vec;
  logic [ENTRIES-1:0] fl_vec;
  logic [ENTRIES-1:0] inv_vec;
  logic               found;
  logic [IDX_W-1:0]   sel;
  logic [IDX_W-1:0]   victim;

  logic do_insert;
  logic do_flush_all;
  logic do_flush_page;
  logic do_flush_local;

  always_comb begin
    do_insert      = (mt_op == OP_INSERT);
    do_flush_all   = (mt_op == OP_FLUSH_ALL);
    do_flush_page  = (mt_op == OP_FLUSH_PAGE);
    do_flush_local = (mt_op == OP_FLUSH_LOCAL);
  end

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
    .valid   (s_valid),
    .tag     (s_tag),
    .asn     (s_asn),
    .glob    (s_glob),
    .q_vpn   (lk_vpn),
    .q_asn   (lk_asn),
    .hit_vec (lk_vec)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
    .valid   (s_valid),
    .tag     (s_tag),
    .asn     (s_asn),
    .glob    (s_glob),
    .q_vpn   (mt_vpn),
    .q_asn   (mt_asn),
    .hit_vec (fl_vec)
  );

  tlb_lowest #(.N(ENTRIES), .IDX_W(IDX_W)) u_lowest (
    .req   (lk_vec),
    .found (found),
    .idx   (sel)
  );

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (do_insert),
    .clr   (do_flush_all),
    .ptr   (victim)
  );

  always_comb begin
    inv_vec = '0;
    if (do_flush_page)
      inv_vec = fl_vec;
    else if (do_flush_local)
      inv_vec = s_valid & ~s_glob;
  end

  tlb_store #(
    .N(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .ASN_W(ASN_W),
    .PFN_W(PFN_W), .MODES(MODES)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (do_insert),
    .wr_idx  (victim),
    .wr_vpn  (mt_vpn),
    .wr_asn  (mt_asn),
    .wr_glob (mt_global),
    .wr_pfn  (mt_pfn),
    .wr_rd   (mt_rd_en),
    .wr_wr   (mt_wr_en),
    .wr_frd  (mt_frd),
    .wr_fwr  (mt_fwr),
    .clr_all (do_flush_all),
    .inv_vec (inv_vec),
    .valid   (s_valid),
    .tag     (s_tag),
    .asn     (s_asn),
    .glob    (s_glob),
    .pfn     (s_pfn),
    .rd_en   (s_rd),
    .wr_en_m (s_wr),
    .frd     (s_frd),
    .fwr     (s_fwr)
  );

  always_comb begin
    lk_hit   = found;
    lk_idx   = '0;
    lk_pfn   = '0;
    lk_rd_en = '0;
    lk_wr_en = '0;
    lk_frd   = 1'b0;
    lk_fwr   = 1'b0;
    if (found) begin
      lk_idx   = sel;
      lk_pfn   = s_pfn[sel];
      lk_rd_en = s_rd[sel];
      lk_wr_en = s_wr[sel];
      lk_frd   = s_frd[sel];
      lk_fwr   = s_fwr[sel];
    end
  end

  AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (s_valid[lk_idx] && s_tag[lk_idx] == lk_vpn &&
                (s_glob[lk_idx] || s_asn[lk_idx] == lk_asn))); // R1

  AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    do_insert |=> (s_tag[$past(victim)] == $past(mt_vpn) &&
                   s_pfn[$past(victim)] == $past(mt_pfn))); // R4

  AST_FLUSH_ALL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    do_flush_all |=> (victim == '0 && s_valid == '0)); // R5

  AST_LOCAL_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    do_flush_local |=> ((s_valid & ~s_glob) == '0)); // R7

  AST_PAGE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    do_flush_page |=> ((s_valid & $past(fl_vec)) == '0)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_op == OP_IDLE || mt_op > OP_FLUSH_LOCAL) |=>
      ($stable(s_valid) && $stable(victim))); // R10
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  localparam int N  = 8;
  localparam int VW = 12;
  localparam int AW = 4;
  localparam int PW = 16;
  localparam int MW = 4;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [VW-1:0] lk_vpn;
  logic [AW-1:0] lk_asn;
  logic          lk_hit;
  logic [IW-1:0] lk_idx;
  logic [PW-1:0] lk_pfn;
  logic [MW-1:0] lk_rd_en, lk_wr_en;
  logic          lk_frd, lk_fwr;
  logic [2:0]    mt_op;
  logic [VW-1:0] mt_vpn;
  logic [AW-1:0] mt_asn;
  logic          mt_global;
  logic [PW-1:0] mt_pfn;
  logic [MW-1:0] mt_rd_en, mt_wr_en;
  logic          mt_frd, mt_fwr;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // behavioural reference
  bit          m_v   [N];
  int unsigned m_vpn [N];
  int unsigned m_asn [N];
  bit          m_g   [N];
  int unsigned m_pfn [N];
  int unsigned m_rd  [N];
  int unsigned m_wr  [N];
  bit          m_frd [N];
  bit          m_fwr [N];
  int          m_ptr;

  always #5 clk = ~clk;

  asid_tlb #(.ENTRIES(N), .VPN_W(VW), .ASN_W(AW), .PFN_W(PW), .MODES(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pfn(lk_pfn), .lk_rd_en(lk_rd_en),
    .lk_wr_en(lk_wr_en), .lk_frd(lk_frd), .lk_fwr(lk_fwr), .mt_op(mt_op),
    .mt_vpn(mt_vpn), .mt_asn(mt_asn), .mt_global(mt_global), .mt_pfn(mt_pfn),
    .mt_rd_en(mt_rd_en), .mt_wr_en(mt_wr_en), .mt_frd(mt_frd), .mt_fwr(mt_fwr)
  );

  function automatic int ref_find(input int unsigned vpn, input int unsigned asn);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asn[i] == asn)) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input string what,
                     input int unsigned act, input int unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic ref_apply();
    int unsigned op = mt_op;
    case (op)
      1: begin
        m_v[m_ptr] = 1; m_vpn[m_ptr] = mt_vpn; m_asn[m_ptr] = mt_asn;
        m_g[m_ptr] = mt_global; m_pfn[m_ptr] = mt_pfn; m_rd[m_ptr] = mt_rd_en;
        m_wr[m_ptr] = mt_wr_en; m_frd[m_ptr] = mt_frd; m_fwr[m_ptr] = mt_fwr;
        m_ptr = (m_ptr + 1) % N;
      end
      2: begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_ptr = 0;
      end
      3: for (int i = 0; i < N; i++)
           if (m_v[i] && m_vpn[i] == mt_vpn && (m_g[i] || m_asn[i] == mt_asn)) m_v[i] = 0;
      4: for (int i = 0; i < N; i++) if (!m_g[i]) m_v[i] = 0;
      default: ;
    endcase
  endtask

  // one clock: drive at negedge, compare combinational lookup, then advance model
  task automatic cyc(input string tag, input int op, input int unsigned vpn,
                     input int unsigned asn, input bit g, input int unsigned pfn,
                     input int unsigned lvpn, input int unsigned lasn);
    int e;
    mt_op = op[2:0]; mt_vpn = vpn[VW-1:0]; mt_asn = asn[AW-1:0]; mt_global = g;
    mt_pfn = pfn[PW-1:0]; mt_rd_en = pfn[MW-1:0]; mt_wr_en = pfn[MW+3:4];
    mt_frd = pfn[8]; mt_fwr = pfn[9];
    lk_vpn = lvpn[VW-1:0]; lk_asn = lasn[AW-1:0];
    #1;
    e = ref_find(lvpn, lasn);
    chk(tag, "hit R1", lk_hit, (e >= 0));
    if (e >= 0) begin
      chk(tag, "idx R2", lk_idx, e);
      chk(tag, "pfn R3", lk_pfn, m_pfn[e]);
      chk(tag, "rd R3", lk_rd_en, m_rd[e]);
      chk(tag, "wr R3", lk_wr_en, m_wr[e]);
      chk(tag, "frd R3", lk_frd, m_frd[e]);
      chk(tag, "fwr R3", lk_fwr, m_fwr[e]);
    end else begin
      chk(tag, "miss zero R3", {lk_idx, lk_pfn, lk_rd_en, lk_wr_en, lk_frd, lk_fwr}, 0);
    end
    @(posedge clk);
    ref_apply();
    @(negedge clk);
  endtask

  task automatic look(input string tag, input int unsigned v, input int unsigned a);
    cyc(tag, 0, 0, 0, 0, 0, v, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_ptr = 0;
    rst_n = 0; mt_op = 0; mt_vpn = 0; mt_asn = 0; mt_global = 0; mt_pfn = 0;
    mt_rd_en = 0; mt_wr_en = 0; mt_frd = 0; mt_fwr = 0; lk_vpn = 0; lk_asn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R8: empty after reset
    for (int v = 0; v < 4; v++) look("R8", v, 0);

    // R4: fill every slot, then wrap and overwrite slot 0
    for (int i = 0; i < N; i++) cyc("R4", 1, 16 + i, 1, 0, 16'h1000 + i * 37, 16, 1);
    for (int i = 0; i < N; i++) look("R4", 16 + i, 1);
    cyc("R4", 1, 40, 2, 0, 16'h3abc, 16, 1);
    look("R4", 16, 1);
    look("R4", 40, 2);
    look("R1", 17, 2);

    // R5: flush all, pointer back to 0
    cyc("R5", 2, 0, 0, 0, 0, 17, 1);
    for (int i = 0; i < 3; i++) look("R5", 17 + i, 1);

    // R2: duplicates of page 5
    cyc("R2", 1, 5, 1, 0, 16'h0111, 5, 1);
    cyc("R2", 1, 5, 2, 0, 16'h0222, 5, 1);
    cyc("R2", 1, 5, 9, 1, 16'h0333, 5, 1);
    look("R2", 5, 1); look("R2", 5, 2); look("R2", 5, 3);

    // R6: flush page 5 in space 2 takes slot 1 and the global slot 2
    cyc("R6", 3, 5, 2, 0, 0, 5, 2);
    look("R6", 5, 2); look("R6", 5, 1); look("R6", 5, 7);

    // R7: flush non-global keeps global entries
    cyc("R7", 1, 7, 3, 1, 16'h0777, 7, 0);
    cyc("R7", 1, 8, 3, 0, 16'h0888, 7, 0);
    cyc("R7", 4, 0, 0, 0, 0, 7, 5);
    look("R7", 5, 1); look("R7", 7, 12); look("R7", 8, 3);

    // R10: unused opcodes change nothing; next insert goes where the pointer was
    cyc("R10", 6, 7, 3, 0, 0, 7, 3);
    cyc("R10", 5, 7, 3, 0, 0, 7, 3);
    cyc("R10", 7, 7, 3, 0, 0, 7, 3);
    cyc("R10", 1, 50, 0, 0, 16'h0555, 7, 1);
    look("R10", 50, 0);

    // R9: same-cycle insert is not seen by the lookup
    cyc("R9", 1, 60, 4, 0, 16'h0666, 60, 4);
    look("R9", 60, 4);

    // random mix over small pools
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      int op = (r < 45) ? 1 : (r < 55) ? 3 : (r < 60) ? 4 : (r < 62) ? 2 :
               (r < 65) ? 6 : 0;
      cyc("R1", op, $urandom_range(0, 11), $urandom_range(0, 3),
          ($urandom_range(0, 3) == 0), $urandom_range(0, 65535),
          $urandom_range(0, 11), $urandom_range(0, 3));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule